// File: doc/BRIEF.md
# Tree-Node Fetch Unit with One-Line Cache

This unit sits between a tree-traversal pipeline and a wide read port on external memory. The pipeline asks for 64-bit tree nodes by node index. External memory returns 512-bit lines, and each line holds eight consecutive nodes. The unit keeps the most recently requested line in a single line buffer. A request that falls in that line is served without touching memory. Any other request issues one line read, and the unit picks the addressed node out of the returned line.

Each external read is also classified against the 8 KB page opened by the previous external read. Three statistics counters record cached hits, page hits and page misses, which lets software estimate memory cost: a same-page read occupies the memory for about two cycles, and a page change costs about ten.

Memory latency can be long, so accepted requests are recorded in an in-order tag queue. This lets new requests, and the line reads they cause, run well ahead of the answers. Responses always come back in request order.

Top module: `node_fetch_cache`

## Requirements
- R1: After reset all three counters read zero, `rsp_valid` and `mem_req_valid` are low, and the line buffer is invalid, so the first request after reset is never a cached hit.
- R2: Every accepted request yields exactly one `rsp_valid` pulse carrying the 64-bit node at the requested index, and responses appear in the order the requests were accepted.
- R3: A request whose line index (node index shifted right by 3) equals the line of the most recent line read, while the line buffer is valid, issues no external read and increments the cached-hit counter.
- R4: Any other request issues exactly one line read with `mem_req_line` equal to the node index shifted right by 3. Node k of a line (k = low 3 bits of the index) is taken from bits [64k+63:64k] of `mem_rsp_data`.
- R5: A page is 128 lines (8 KB). A line read goes to the page-hit counter when its page (line index shifted right by 7) matches the page of the previous line read. Otherwise it goes to the page-miss counter, and this includes the first line read after reset.
- R6: Each counter holds at its all-ones value instead of wrapping.
- R7: `stat_clr` zeroes all counters on the next clock edge and leaves the line buffer intact, so a following request to the buffered line is still a cached hit.
- R8: At most TAG_DEPTH requests are outstanding. `req_ready` drops while the queue is full, a pending line read holds its line stable until accepted, and no request is lost under long memory latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stat_clr | input | 1 | Synchronous clear of the statistics counters |
| req_valid | input | 1 | Node request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_addr | input | ADDR_W | Node index |
| rsp_valid | output | 1 | Node data valid (one pulse per request) |
| rsp_data | output | 64 | Requested node |
| mem_req_valid | output | 1 | Line read pending |
| mem_req_ready | input | 1 | Memory takes the line read |
| mem_req_line | output | ADDR_W-3 | Line index to read |
| mem_rsp_valid | input | 1 | Line data available (in order) |
| mem_rsp_ready | output | 1 | Unit consumes the line data |
| mem_rsp_data | input | 512 | Returned line, node k at bits [64k+63:64k] |
| cnt_cached | output | CNT_W | Cached-hit count |
| cnt_page_hit | output | CNT_W | Same-page line reads |
| cnt_page_miss | output | CNT_W | Page-changing line reads |

## Verification
The bench builds the unit with a 12-bit node index, which gives only four pages, so page crossings and returns to an earlier page occur within a few hundred requests. The tag queue has depth 4, so a 60-cycle memory latency fills it and exercises the `req_ready` stall. The counters are 8 bits wide, so 300 repeated hits drive the cached counter into saturation. Each response and each line read is compared against node values that the bench computes arithmetically from the node index, and the counters are compared against a running classification model kept in the bench.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  localparam int NODE_W     = 64;
  localparam int NODES_LINE = 8;
  localparam int LINE_W     = NODE_W * NODES_LINE;
  localparam int OFF_W      = $clog2(NODES_LINE);
  localparam int LINE_BYTES = LINE_W / 8;

  typedef struct packed {
    logic             hit;
    logic [OFF_W-1:0] off;
  } tag_t;

  localparam int TAG_W = $bits(tag_t);

  function automatic logic [NODE_W-1:0] pick_node(input logic [LINE_W-1:0] line,
                                                  input logic [OFF_W-1:0]  off);
    return line[off*NODE_W +: NODE_W];
  endfunction
endpackage

// File: rtl/nfc_tag_fifo.sv
module nfc_tag_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);
  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dout = store[rd_ptr];
endmodule

// File: rtl/nfc_lookup.sv
module nfc_lookup #(
  parameter int LINE_AW = 21,
  parameter int PAGE_SH = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc,
  input  logic [LINE_AW-1:0] line,
  output logic               hit,
  output logic               page_same
);
  localparam int PG_W = LINE_AW - PAGE_SH;

  logic               buf_vld;
  logic [LINE_AW-1:0] last_line;
  logic [PG_W-1:0]    last_page;
  logic [PG_W-1:0]    page;

  assign page      = line[LINE_AW-1:PAGE_SH];
  assign hit       = buf_vld && (line == last_line);
  assign page_same = buf_vld && (page == last_page);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_vld   <= 1'b0;
      last_line <= '0;
      last_page <= '0;
    end else if (acc && !hit) begin
      buf_vld   <= 1'b1;
      last_line <= line;
      last_page <= page;
    end
  end
endmodule

// File: rtl/nfc_sat_counter.sv
module nfc_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr)           value <= '0;
    else if (inc && value != '1) value <= value + 1'b1;
  end
endmodule

// File: rtl/node_fetch_cache.sv
module node_fetch_cache
  import nfc_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int PAGE_BYTES = 8192,
  parameter int TAG_DEPTH  = 16,
  parameter int CNT_W      = 32,
  localparam int LINE_AW   = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stat_clr,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               rsp_valid,
  output logic [63:0]        rsp_data,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [LINE_AW-1:0] mem_req_line,
  input  logic               mem_rsp_valid,
  output logic               mem_rsp_ready,
  input  logic [511:0]       mem_rsp_data,
  output logic [CNT_W-1:0]   cnt_cached,
  output logic [CNT_W-1:0]   cnt_page_hit,
  output logic [CNT_W-1:0]   cnt_page_miss
);
  localparam int PAGE_SH = $clog2(PAGE_BYTES / LINE_BYTES);
  localparam int TCW     = $clog2(TAG_DEPTH + 1);

  // named internal events
  logic               acc, acc_hit, acc_page_same, pop;
  logic [LINE_AW-1:0] acc_line;
  logic [OFF_W-1:0]   acc_off;
  logic [TCW-1:0]     tag_count;
  logic               tag_full, head_vld;
  tag_t               head, push_tag;
  logic [LINE_W-1:0]  line_buf;

  assign acc_line = req_addr[ADDR_W-1:OFF_W];
  assign acc_off  = req_addr[OFF_W-1:0];
  assign tag_full = (tag_count == TCW'(TAG_DEPTH));
  assign head_vld = (tag_count != '0);

  assign req_ready = !tag_full && (!mem_req_valid || mem_req_ready);
  assign acc       = req_valid && req_ready;

  nfc_lookup #(.LINE_AW(LINE_AW), .PAGE_SH(PAGE_SH)) u_lookup (
    .clk(clk), .rst_n(rst_n), .acc(acc), .line(acc_line),
    .hit(acc_hit), .page_same(acc_page_same)
  );

  assign push_tag = '{hit: acc_hit, off: acc_off};

  nfc_tag_fifo #(.DEPTH(TAG_DEPTH), .W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .push(acc), .din(push_tag),
    .pop(pop), .dout(head), .count(tag_count)
  );

  // line read issue
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req_valid <= 1'b0;
      mem_req_line  <= '0;
    end else if (acc && !acc_hit) begin
      mem_req_valid <= 1'b1;
      mem_req_line  <= acc_line;
    end else if (mem_req_ready) begin
      mem_req_valid <= 1'b0;
    end
  end

  // in-order answer
  assign mem_rsp_ready = head_vld && !head.hit;
  assign pop           = head_vld && (head.hit || mem_rsp_valid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= pop;
      if (pop)
        rsp_data <= head.hit ? pick_node(line_buf, head.off)
                             : pick_node(mem_rsp_data, head.off);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     line_buf <= '0;
    else if (pop && !head.hit)      line_buf <= mem_rsp_data;
  end

  // statistics
  logic [2:0]       ev_inc;
  logic [CNT_W-1:0] ev_val [3];

  assign ev_inc[0] = acc && acc_hit;
  assign ev_inc[1] = acc && !acc_hit && acc_page_same;
  assign ev_inc[2] = acc && !acc_hit && !acc_page_same;

  for (genvar g = 0; g < 3; g++) begin : g_cnt
    nfc_sat_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(stat_clr),
      .inc(ev_inc[g]), .value(ev_val[g])
    );
  end

  assign cnt_cached    = ev_val[0];
  assign cnt_page_hit  = ev_val[1];
  assign cnt_page_miss = ev_val[2];
endmodule

// File: rtl/nfc_checker.sv
module nfc_checker #(
  parameter int LINE_AW   = 21,
  parameter int TCW       = 5,
  parameter int TAG_DEPTH = 16,
  parameter int CNT_W     = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               stat_clr,
  input logic               acc,
  input logic               acc_hit,
  input logic [LINE_AW-1:0] acc_line,
  input logic               pop,
  input logic [TCW-1:0]     tag_count,
  input logic               rsp_valid,
  input logic               mem_req_valid,
  input logic               mem_req_ready,
  input logic [LINE_AW-1:0] mem_req_line,
  input logic               mem_rsp_ready,
  input logic [CNT_W-1:0]   cnt_cached,
  input logic [CNT_W-1:0]   cnt_page_hit,
  input logic [CNT_W-1:0]   cnt_page_miss
);
  // R2
  answer_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> rsp_valid);

  // R2
  line_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_ready |-> tag_count != '0);

  // R3
  hit_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && acc_hit |=> !mem_req_valid);

  // R3
  hit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && acc_hit && !stat_clr && cnt_cached != '1
    |=> cnt_cached == $past(cnt_cached) + 1'b1);

  // R4
  miss_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !acc_hit |=> mem_req_valid && mem_req_line == $past(acc_line));

  // R6
  sat_cached_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_clr && cnt_cached == '1 |=> cnt_cached == '1);

  // R6
  sat_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_clr && cnt_page_hit == '1 && cnt_page_miss == '1
    |=> cnt_page_hit == '1 && cnt_page_miss == '1);

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr |=> cnt_cached == '0 && cnt_page_hit == '0 && cnt_page_miss == '0);

  // R8
  depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_count <= TCW'(TAG_DEPTH));

  // R8
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_line));
endmodule

bind node_fetch_cache nfc_checker #(
  .LINE_AW(LINE_AW), .TCW(TCW), .TAG_DEPTH(TAG_DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .stat_clr(stat_clr), .acc(acc), .acc_hit(acc_hit),
  .acc_line(acc_line), .pop(pop), .tag_count(tag_count), .rsp_valid(rsp_valid),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_line(mem_req_line), .mem_rsp_ready(mem_rsp_ready),
  .cnt_cached(cnt_cached), .cnt_page_hit(cnt_page_hit), .cnt_page_miss(cnt_page_miss)
);

// File: tb/node_fetch_cache_tb.sv
module node_fetch_cache_tb;
  localparam int AW = 12;
  localparam int LAW = AW - 3;
  localparam int DEPTH = 4;
  localparam int CW = 8;
  localparam int MAXC = 255;

  logic clk, rst_n, stat_clr, req_valid, req_ready;
  logic [AW-1:0] req_addr;
  logic rsp_valid;
  logic [63:0] rsp_data;
  logic mem_req_valid, mem_req_ready, mem_rsp_valid, mem_rsp_ready;
  logic [LAW-1:0] mem_req_line;
  logic [511:0] mem_rsp_data;
  logic [CW-1:0] cnt_cached, cnt_page_hit, cnt_page_miss;

  node_fetch_cache #(.ADDR_W(AW), .PAGE_BYTES(8192), .TAG_DEPTH(DEPTH), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .stat_clr(stat_clr), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_line(mem_req_line), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .cnt_cached(cnt_cached), .cnt_page_hit(cnt_page_hit), .cnt_page_miss(cnt_page_miss)
  );

  int checks = 0, failures = 0, cyc = 0;
  int lat = 4, rdy_mode = 0, stall_seen = 0, mem_reads = 0;
  // bench model
  int m_cached = 0, m_ph = 0, m_pm = 0, m_line = 0, m_page = 0, m_vld = 0;
  logic [63:0] exp_q [64];
  int e_rd = 0, e_wr = 0, e_n = 0;
  int miss_q [64];
  int x_rd = 0, x_wr = 0;
  int mq_line [16], mq_due [16];
  int mq_rd = 0, mq_wr = 0, mq_n = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  function automatic logic [63:0] node_val(input int a);
    logic [31:0] x;
    x = a;
    return {x * 32'h9E3779B1, x ^ 32'hC0DE0000};
  endfunction

  function automatic logic [511:0] line_data(input int l);
    logic [511:0] d;
    for (int i = 0; i < 8; i++) d[64*i +: 64] = node_val(l * 8 + i);
    return d;
  endfunction

  task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model
  always @(negedge clk) begin
    mem_req_ready = (rdy_mode == 0) ? 1'b1 : (cyc % 2 == 0);
    mem_rsp_valid = (mq_n > 0) && (cyc >= mq_due[mq_rd]);
    mem_rsp_data  = (mq_n > 0) ? line_data(mq_line[mq_rd]) : '0;
    #9;
    if (mem_rsp_valid && mem_rsp_ready) begin
      mq_rd = (mq_rd + 1) % 16; mq_n--;
    end
    if (mem_req_valid && mem_req_ready) begin
      // R4 line index of each read
      check_eq("R4 read line", 64'(mem_req_line), 64'(miss_q[x_rd]));
      x_rd = (x_rd + 1) % 64;
      mq_line[mq_wr] = int'(mem_req_line); mq_due[mq_wr] = cyc + lat;
      mq_wr = (mq_wr + 1) % 16; mq_n++; mem_reads++;
    end
  end

  // response monitor
  always @(negedge clk) begin
    #9;
    if (rst_n && rsp_valid) begin
      if (e_n == 0) check_eq("R2 unexpected answer", 64'(1), 64'(0));
      else begin
        check_eq("R2 R4 node data", rsp_data, exp_q[e_rd]);
        e_rd = (e_rd + 1) % 64; e_n--;
      end
    end
  end

  task automatic model_accept(input int a);
    int l, p;
    l = a >> 3; p = l >> 7;
    if (m_vld == 1 && l == m_line) begin
      if (m_cached < MAXC) m_cached++;
    end else begin
      miss_q[x_wr] = l; x_wr = (x_wr + 1) % 64;
      if (m_vld == 1 && p == m_page) begin if (m_ph < MAXC) m_ph++; end
      else begin if (m_pm < MAXC) m_pm++; end
      m_line = l; m_page = p; m_vld = 1;
    end
    exp_q[e_wr] = node_val(a); e_wr = (e_wr + 1) % 64; e_n++;
  endtask

  task automatic send(input int a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = AW'(a);
    forever begin
      #9;
      if (req_ready) begin model_accept(a); break; end
      stall_seen = 1;
      @(negedge clk);
    end
  endtask

  task automatic idle_drain();
    @(negedge clk); req_valid = 1'b0;
    while (e_n != 0 || mq_n != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_stats();
    @(negedge clk); stat_clr = 1'b1;
    @(negedge clk); stat_clr = 1'b0;
    m_cached = 0; m_ph = 0; m_pm = 0;
  endtask

  task automatic check_counts(input string tag);
    check_eq({tag, " R3 cached"}, 64'(cnt_cached), 64'(m_cached));
    check_eq({tag, " R5 page hit"}, 64'(cnt_page_hit), 64'(m_ph));
    check_eq({tag, " R5 page miss"}, 64'(cnt_page_miss), 64'(m_pm));
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int rd0;
    rst_n = 1'b0; stat_clr = 1'b0; req_valid = 1'b0; req_addr = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check_eq("R1 cached", 64'(cnt_cached), 0);
    check_eq("R1 page hit", 64'(cnt_page_hit), 0);
    check_eq("R1 page miss", 64'(cnt_page_miss), 0);
    check_eq("R1 rsp_valid", 64'(rsp_valid), 0);
    check_eq("R1 mem_req_valid", 64'(mem_req_valid), 0);
    rst_n = 1'b1;

    // sequential sweep: 8 lines on one page
    for (int a = 0; a < 64; a++) send(a);
    idle_drain();
    check_counts("seq");
    check_eq("R3 seq cached arith", 64'(cnt_cached), 56);
    check_eq("R5 seq first read is page miss", 64'(cnt_page_miss), 1);
    check_eq("R5 seq same page", 64'(cnt_page_hit), 7);

    // scrambled offsets across a page boundary, throttled memory
    clear_stats(); rdy_mode = 1; lat = 30;
    for (int l = 120; l < 136; l++)
      for (int k = 0; k < 8; k++) send(l * 8 + (k * 3) % 8);
    idle_drain();
    check_counts("cross");

    // alternating pages: every access a page change
    clear_stats(); rdy_mode = 0; lat = 5;
    for (int i = 0; i < 20; i++) send(((i % 2 == 0) ? 5 : 300) * 8 + i % 8);
    idle_drain();
    check_counts("alt");
    check_eq("R5 alternating all misses", 64'(cnt_page_miss), 20);

    // long latency, distinct lines: queue fills
    clear_stats(); lat = 60; stall_seen = 0;
    for (int i = 0; i < 20; i++) send((200 + i) * 8 + 7);
    idle_drain();
    check_counts("deep");
    check_eq("R8 full queue stalls requests", 64'(stall_seen), 1);
    check_eq("R8 nothing outstanding", 64'(e_n), 0);

    // clear keeps the line buffer
    lat = 4;
    clear_stats();
    check_counts("R7 after clear");
    rd0 = mem_reads;
    send(219 * 8 + 2);
    idle_drain();
    check_eq("R7 buffered line still hits", 64'(cnt_cached), 1);
    check_eq("R7 no read after clear", 64'(mem_reads), 64'(rd0));

    // saturation
    clear_stats();
    for (int i = 0; i < 300; i++) send(219 * 8 + i % 8);
    idle_drain();
    check_eq("R6 cached saturates", 64'(cnt_cached), MAXC);
    check_counts("sat");

    // reset invalidates the buffer
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    m_vld = 0; m_cached = 0; m_ph = 0; m_pm = 0;
    send(219 * 8 + 1);
    idle_drain();
    check_eq("R1 first request after reset misses", 64'(cnt_page_miss), 1);
    check_eq("R1 no hit after reset", 64'(cnt_cached), 0);
    check_counts("reset");

    summary();
  end
endmodule